// File: doc/BRIEF.md
# Coprocessor Context-Save Sequencer

This block is the main-processor-side controller that carries out a coprocessor state-save instruction. A one-cycle start pulse begins the sequence. It comes with a supervisor flag and a base effective address that an external address unit has already computed. The sequencer polls the coprocessor's save register for a format word. While the coprocessor answers "not ready", it can stop between polls to let pending interrupts be serviced. Once a usable format arrives, it stores the format word and then copies the coprocessor's internal state, one 32-bit word at a time, from the operand register to memory.

The coprocessor is reached through a small register-access port. A two-bit select on that port picks the save, control or operand register. Memory is reached through a separate write port. Both ports use a valid/ready handshake, and the sequencer holds a request steady for as long as ready stays low. The sequence ends with exactly one single-cycle indication: completion, privilege violation or format error. Exception handling itself belongs to the surrounding core.

Top module: `cp_ctx_save_seq`

## Requirements
- R1: A start with `super_i` low yields a one-cycle `priv_err_o` pulse in the cycle after start, and no coprocessor register access or memory write.
- R2: A start with `super_i` high makes, as its first access, a read of the save register (`cir_sel_o` = 0, `cir_we_o` = 0) in the cycle after start.
- R3: A format word whose code (bits [31:24]) is 0x01 means not ready. If `irq_pend_i` is high when that word is accepted, `irq_svc_o` rises and stays high until `irq_ack_i`, and then the save register is read again. If `irq_pend_i` is low, the save register is read again directly.
- R4: A ready format word is written unchanged to memory at address `ea_i`, before any operand-register read.
- R5: A format with code 0x00 (empty), or a valid code whose length field (bits [23:16]) is zero, finishes with a `done_o` pulse right after the format word is stored. No operand read follows.
- R6: Otherwise the length field gives a byte count N. There are N/4 pairs of one operand-register read (`cir_sel_o` = 2) followed by a memory write of the data read. The writes go to `ea_i`+4, `ea_i`+8 and so on, and a `done_o` pulse follows the last write.
- R7: Code 0x0F, or a length with bits [1:0] not zero, counts as invalid unless the code is 0x01. An invalid format gives a write of 0x0000_0001 to the control register (`cir_sel_o` = 1, `cir_we_o` = 1), then a `fmt_err_o` pulse, and no memory write.
- R8: While a request's valid is high and ready is low, the request stays asserted with unchanged select, write-enable, address and data. The register port and the memory port are never active in the same cycle.
- R9: `done_o`, `fmt_err_o` and `priv_err_o` are single-cycle pulses, at most one at a time and exactly one per accepted start. A start while `busy_o` is high is ignored.
- R10: After reset, both valid outputs, `irq_svc_o`, `busy_o` and all three result pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a save instruction (ignored while busy) |
| super_i | input | 1 | Supervisor privilege level, sampled with start |
| ea_i | input | AW | Base effective address, sampled with start |
| irq_pend_i | input | 1 | An interrupt is waiting for service |
| irq_svc_o | output | 1 | Request to service pending interrupts |
| irq_ack_i | input | 1 | Interrupt service finished |
| cir_valid_o | output | 1 | Coprocessor register access request |
| cir_ready_i | input | 1 | Coprocessor accepts the access |
| cir_sel_o | output | 2 | 0 save, 1 control, 2 operand |
| cir_we_o | output | 1 | 1 write, 0 read |
| cir_wdata_o | output | 32 | Write data (abort mask) |
| cir_rdata_i | input | 32 | Read data, valid in the accepting cycle |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_addr_o | output | AW | Write address |
| mem_wdata_o | output | 32 | Write data |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Save completed (pulse) |
| priv_err_o | output | 1 | Privilege violation (pulse) |
| fmt_err_o | output | 1 | Format error (pulse) |

## Verification
The bench targets several corner cases. Repeated not-ready answers, with and without a pending interrupt, would show any missed or extra interrupt handshake, or a poll skipped after service. Two invalid forms, a reserved code and a length that is not word-aligned, would catch a design that stores the format word or skips the abort write. An empty format and a zero-length valid format would catch a design that reads the operand register once too often. A 63-word save under random back-pressure exposes an off-by-one word count, a wrong address step, or a request that changes while it waits, and a second start pulse during a busy run would create a duplicate sequence if it were not ignored.

// File: rtl/cp_save_pkg.sv
package cp_save_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 8;
  localparam int unsigned CNT_W  = LEN_W - 2;

  localparam logic [7:0] CODE_EMPTY   = 8'h00;
  localparam logic [7:0] CODE_NOTRDY  = 8'h01;
  localparam logic [7:0] CODE_INVALID = 8'h0F;
  localparam logic [WORD_W-1:0] ABORT_MASK = 32'h0000_0001;

  localparam logic [1:0] SEL_SAVE = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_OPND = 2'd2;

  typedef enum logic [1:0] {FK_NOTRDY, FK_BAD, FK_EMPTY, FK_DATA} fmt_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_SAVE, S_IRQ, S_WR_FMT, S_RD_OP, S_WR_DAT,
    S_ABORT, S_DONE, S_FERR, S_PERR
  } state_e;
endpackage

// File: rtl/cp_fmt_decode.sv
module cp_fmt_decode
  import cp_save_pkg::*;
(
  input  logic [15:0]      hdr_i,   // format word bits [31:16]
  output fmt_kind_e        kind_o,
  output logic [CNT_W-1:0] nwords_o
);
  logic [7:0] code;
  logic [LEN_W-1:0] len;
  assign code = hdr_i[15:8];
  assign len  = hdr_i[LEN_W-1:0];

  // not-ready wins, then invalid, then empty / zero length
  always_comb begin
    nwords_o = '0;
    if (code == CODE_NOTRDY) begin
      kind_o = FK_NOTRDY;
    end else if (code == CODE_INVALID || len[1:0] != 2'b00) begin
      kind_o = FK_BAD;
    end else if (code == CODE_EMPTY || len == '0) begin
      kind_o = FK_EMPTY;
    end else begin
      kind_o   = FK_DATA;
      nwords_o = len[LEN_W-1:2];
    end
  end
endmodule

// File: rtl/cp_xfer_ctr.sv
module cp_xfer_ctr #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_addr_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          ld_cnt_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dec_i,
  output logic [AW-1:0] addr_o,
  output logic          zero_o,
  output logic          last_o
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (ld_addr_i) begin
      addr_q <= base_i;
    end else if (adv_i) begin
      addr_q <= addr_q + STEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_cnt_i) begin
      cnt_q <= cnt_i;
    end else if (dec_i) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign addr_o = addr_q;
  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/cp_ctx_save_seq.sv
module cp_ctx_save_seq
  import cp_save_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              super_i,
  input  logic [AW-1:0]     ea_i,
  input  logic              irq_pend_i,
  output logic              irq_svc_o,
  input  logic              irq_ack_i,
  output logic              cir_valid_o,
  input  logic              cir_ready_i,
  output logic [1:0]        cir_sel_o,
  output logic              cir_we_o,
  output logic [WORD_W-1:0] cir_wdata_o,
  input  logic [WORD_W-1:0] cir_rdata_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              priv_err_o,
  output logic              fmt_err_o
);
  state_e state_q, state_d;
  logic [WORD_W-1:0] word_q;
  logic cap_word;
  logic ld_addr, adv, ld_cnt, dec, cnt_zero, cnt_last;
  fmt_kind_e kind;
  logic [CNT_W-1:0] nwords;
  logic cir_hs, mem_hs;

  cp_fmt_decode u_dec (
    .hdr_i    (cir_rdata_i[WORD_W-1:WORD_W-16]),
    .kind_o   (kind),
    .nwords_o (nwords)
  );

  cp_xfer_ctr #(.AW(AW), .CW(CNT_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_addr_i (ld_addr),
    .base_i    (ea_i),
    .adv_i     (adv),
    .ld_cnt_i  (ld_cnt),
    .cnt_i     (nwords),
    .dec_i     (dec),
    .addr_o    (mem_addr_o),
    .zero_o    (cnt_zero),
    .last_o    (cnt_last)
  );

  assign cir_hs = cir_valid_o && cir_ready_i;
  assign mem_hs = mem_valid_o && mem_ready_i;

  always_comb begin
    state_d     = state_q;
    cir_valid_o = 1'b0;
    cir_sel_o   = SEL_SAVE;
    cir_we_o    = 1'b0;
    mem_valid_o = 1'b0;
    irq_svc_o   = 1'b0;
    cap_word    = 1'b0;
    ld_addr     = 1'b0;
    adv         = 1'b0;
    ld_cnt      = 1'b0;
    dec         = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          ld_addr = 1'b1;
          state_d = super_i ? S_RD_SAVE : S_PERR;
        end
      end
      S_RD_SAVE: begin
        cir_valid_o = 1'b1;
        if (cir_hs) begin
          unique case (kind)
            FK_NOTRDY: state_d = irq_pend_i ? S_IRQ : S_RD_SAVE;
            FK_BAD:    state_d = S_ABORT;
            default: begin
              cap_word = 1'b1;
              ld_cnt   = 1'b1;
              state_d  = S_WR_FMT;
            end
          endcase
        end
      end
      S_IRQ: begin
        irq_svc_o = 1'b1;
        if (irq_ack_i) state_d = S_RD_SAVE;
      end
      S_WR_FMT: begin
        mem_valid_o = 1'b1;
        if (mem_hs) begin
          adv     = 1'b1;
          state_d = cnt_zero ? S_DONE : S_RD_OP;
        end
      end
      S_RD_OP: begin
        cir_valid_o = 1'b1;
        cir_sel_o   = SEL_OPND;
        if (cir_hs) begin
          cap_word = 1'b1;
          state_d  = S_WR_DAT;
        end
      end
      S_WR_DAT: begin
        mem_valid_o = 1'b1;
        if (mem_hs) begin
          adv     = 1'b1;
          dec     = 1'b1;
          state_d = cnt_last ? S_DONE : S_RD_OP;
        end
      end
      S_ABORT: begin
        cir_valid_o = 1'b1;
        cir_sel_o   = SEL_CTRL;
        cir_we_o    = 1'b1;
        if (cir_hs) state_d = S_FERR;
      end
      default: state_d = S_IDLE;  // result states last one cycle
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_q <= '0;
    else if (cap_word) word_q <= cir_rdata_i;
  end

  assign mem_wdata_o = word_q;
  assign cir_wdata_o = (state_q == S_ABORT) ? ABORT_MASK : '0;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign fmt_err_o   = (state_q == S_FERR);
  assign priv_err_o  = (state_q == S_PERR);
endmodule

// File: rtl/cp_ctx_save_seq_chk.sv
module cp_ctx_save_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          super_i,
  input logic          irq_svc_o,
  input logic          irq_ack_i,
  input logic          cir_valid_o,
  input logic          cir_ready_i,
  input logic [1:0]    cir_sel_o,
  input logic          cir_we_o,
  input logic [31:0]   cir_wdata_o,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          priv_err_o,
  input logic          fmt_err_o
);
  p_priv_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !super_i && !busy_o) |=> (priv_err_o && !cir_valid_o && !mem_valid_o));

  p_first_save_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && super_i && !busy_o) |=> (cir_valid_o && cir_sel_o == 2'd0 && !cir_we_o));

  p_irq_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_svc_o && !irq_ack_i) |=> irq_svc_o);

  p_abort_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cir_valid_o && cir_we_o) |-> (cir_sel_o == 2'd1 && cir_wdata_o == 32'h0000_0001));

  p_cir_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cir_valid_o && !cir_ready_i) |=> (cir_valid_o && $stable({cir_sel_o, cir_we_o, cir_wdata_o})));

  p_mem_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable({mem_addr_o, mem_wdata_o})));

  p_port_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cir_valid_o && mem_valid_o));

  p_one_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, priv_err_o, fmt_err_o}));

  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || priv_err_o || fmt_err_o) |=> !(done_o || priv_err_o || fmt_err_o));
endmodule

bind cp_ctx_save_seq cp_ctx_save_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/cp_ctx_save_seq_test.sv
module cp_ctx_save_seq_test;
  localparam int K_RDSAVE = 0, K_RDOP = 1, K_CTRL = 2, K_MEM = 3,
                 K_IRQ = 4, K_DONE = 5, K_FERR = 6, K_PRIV = 7;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, super_i = 1'b0, irq_pend_i = 1'b0, irq_ack_i = 1'b0;
  logic [31:0] ea_i = '0;
  logic cir_valid_o, cir_ready_i = 1'b0, cir_we_o;
  logic [1:0] cir_sel_o;
  logic [31:0] cir_wdata_o, cir_rdata_i = '0;
  logic mem_valid_o, mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic irq_svc_o, busy_o, done_o, priv_err_o, fmt_err_o;

  int checks = 0, fails = 0;
  bit stall_en = 1'b0, finished = 1'b0;

  int          exp_k[$];
  logic [31:0] exp_a[$], exp_d[$];
  string       exp_r[$];
  logic [31:0] sv_q[$], op_q[$], sc_fmts[$];

  logic        pv_cir = 1'b0, pv_mem = 1'b0;
  logic [34:0] pv_cir_f;
  logic [63:0] pv_mem_f;

  always #5 clk_i = ~clk_i;

  cp_ctx_save_seq #(.AW(32)) uut (.*);

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(int k, logic [31:0] a, logic [31:0] d, string r);
    exp_k.push_back(k); exp_a.push_back(a); exp_d.push_back(d); exp_r.push_back(r);
  endtask

  task automatic observe(int k, logic [31:0] a, logic [31:0] d);
    if (exp_k.size() == 0) begin
      chk(1'b0, "R9", "unexpected transaction kind", 64'(k), 64'hFF);
    end else begin
      int ek = exp_k.pop_front();
      logic [31:0] ea = exp_a.pop_front();
      logic [31:0] ed = exp_d.pop_front();
      string er = exp_r.pop_front();
      chk(ek == k && ea == a && ed == d, er, "transaction kind/addr/data",
          {24'(k), a, d[7:0]}, {24'(ek), ea, ed[7:0]});
    end
  endtask

  // responder and monitor: drive ready for the next edge, log what that edge accepts
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pv_cir)
        chk(cir_valid_o && {cir_sel_o, cir_we_o, cir_wdata_o} == pv_cir_f, "R8",
            "register request changed while waiting", 64'({cir_sel_o, cir_we_o, cir_wdata_o}), 64'(pv_cir_f));
      if (pv_mem)
        chk(mem_valid_o && {mem_addr_o, mem_wdata_o} == pv_mem_f, "R8",
            "memory request changed while waiting", {mem_addr_o, mem_wdata_o}, pv_mem_f);
      cir_ready_i = cir_valid_o && !(stall_en && $urandom_range(3) == 0);
      mem_ready_i = mem_valid_o && !(stall_en && $urandom_range(3) == 0);
      irq_ack_i   = irq_svc_o && !(stall_en && $urandom_range(2) != 0);
      pv_cir   = cir_valid_o && !cir_ready_i;
      pv_cir_f = {cir_sel_o, cir_we_o, cir_wdata_o};
      pv_mem   = mem_valid_o && !mem_ready_i;
      pv_mem_f = {mem_addr_o, mem_wdata_o};
      cir_rdata_i = 32'hDEAD_BEEF;
      if (cir_ready_i) begin
        if (cir_we_o) begin
          observe(K_CTRL, 32'(cir_sel_o), cir_wdata_o);
        end else if (cir_sel_o == 2'd0) begin
          observe(K_RDSAVE, 0, 0);
          if (sv_q.size() != 0) cir_rdata_i = sv_q.pop_front();
        end else begin
          observe(K_RDOP, 32'(cir_sel_o), 0);
          if (op_q.size() != 0) cir_rdata_i = op_q.pop_front();
        end
      end
      if (mem_ready_i) observe(K_MEM, mem_addr_o, mem_wdata_o);
      if (irq_ack_i)   observe(K_IRQ, 0, 0);
      if (done_o)      observe(K_DONE, 0, 0);
      if (fmt_err_o)   observe(K_FERR, 0, 0);
      if (priv_err_o)  observe(K_PRIV, 0, 0);
    end
  end

  // expected sequence computed from the requirements
  task automatic build(bit sup, logic [31:0] ea, bit pend);
    if (!sup) begin
      push_exp(K_PRIV, 0, 0, "R1");
      return;
    end
    foreach (sc_fmts[i]) begin
      logic [31:0] f = sc_fmts[i];
      push_exp(K_RDSAVE, 0, 0, (i == 0) ? "R2" : "R3");
      if (f[31:24] == 8'h01) begin
        if (pend) push_exp(K_IRQ, 0, 0, "R3");
        continue;
      end
      if (f[31:24] == 8'h0F || f[17:16] != 2'b00) begin
        push_exp(K_CTRL, 1, 32'h1, "R7");
        push_exp(K_FERR, 0, 0, "R7");
        return;
      end
      push_exp(K_MEM, ea, f, "R4");
      if (f[31:24] != 8'h00) begin
        for (int w = 0; w < int'(f[23:18]); w++) begin
          logic [31:0] d = $urandom;
          op_q.push_back(d);
          push_exp(K_RDOP, 2, 0, "R6");
          push_exp(K_MEM, ea + 32'(4 * (w + 1)), d, "R6");
        end
        push_exp(K_DONE, 0, 0, "R6");
      end else begin
        push_exp(K_DONE, 0, 0, "R5");
      end
      return;
    end
  endtask

  task automatic run_case(bit sup, logic [31:0] ea, bit pend, bit stl, bit retrig);
    sv_q = sc_fmts;
    build(sup, ea, pend);
    irq_pend_i = pend;
    stall_en   = stl;
    @(negedge clk_i);
    start_i = 1'b1; super_i = sup; ea_i = ea;
    @(negedge clk_i);
    start_i = 1'b0;
    if (retrig) begin  // R9: start while busy must be ignored
      repeat (3) @(negedge clk_i);
      start_i = 1'b1; ea_i = 32'h0BAD_0000;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait (exp_k.size() == 0);
    repeat (4) @(negedge clk_i);
    chk(!busy_o && !cir_valid_o && !mem_valid_o, "R9", "idle after sequence", 64'(busy_o), 0);
    chk(op_q.size() == 0, "R5", "operand words left unread", 64'(op_q.size()), 0);
    sc_fmts = {};
    sv_q    = {};
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!cir_valid_o && !mem_valid_o && !irq_svc_o && !busy_o, "R10", "reset outputs",
        {cir_valid_o, mem_valid_o, irq_svc_o, busy_o}, 0);
    chk(!done_o && !priv_err_o && !fmt_err_o, "R10", "reset pulses",
        {done_o, priv_err_o, fmt_err_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    sc_fmts = {32'h2200_0000};                     // R1 user level
    run_case(1'b0, 32'h0000_1000, 1'b1, 1'b0, 1'b0);
    sc_fmts = {32'h0000_0000};                     // R5 empty
    run_case(1'b1, 32'h0000_2000, 1'b0, 1'b0, 1'b0);
    sc_fmts = {32'h250C_1234};                     // R6 three words
    run_case(1'b1, 32'h0000_3000, 1'b0, 1'b0, 1'b0);
    sc_fmts = {32'h0100_0000, 32'h0100_0000, 32'h4104_0000};  // R3 with interrupt service
    run_case(1'b1, 32'h0000_4000, 1'b1, 1'b1, 1'b0);
    sc_fmts = {32'h0108_0000, 32'h0000_0000};      // R3 no interrupt pending
    run_case(1'b1, 32'h0000_5000, 1'b0, 1'b0, 1'b0);
    sc_fmts = {32'h0F08_0000};                     // R7 invalid code
    run_case(1'b1, 32'h0000_6000, 1'b0, 1'b1, 1'b0);
    sc_fmts = {32'h3006_0000};                     // R7 misaligned length
    run_case(1'b1, 32'h0000_7000, 1'b0, 1'b0, 1'b0);
    sc_fmts = {32'h5500_0000};                     // R5 zero length
    run_case(1'b1, 32'h0000_8000, 1'b0, 1'b0, 1'b0);
    sc_fmts = {32'h01FC_0000, 32'h77FC_ABCD};      // R6 max length, back-pressure
    run_case(1'b1, 32'hFFFF_FF00, 1'b1, 1'b1, 1'b0);
    sc_fmts = {32'h2610_0000};                     // R9 restart while busy
    run_case(1'b1, 32'h0001_0000, 1'b0, 1'b1, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp=0", exp_k.size());
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule